// File: doc/BRIEF.md
# Ordered Power-Off Sequencer

This block runs the last steps a chip takes before it cuts its own power. A single start pulse launches a fixed chain of register writes on three simple write ports. The first port goes to the DRAM controller's low-power register. The second goes to the master-clock source select. The third goes to the shutdown controller's control register.

The chain first parks the DRAM in its power-off low-power mode. This step is taken only when the attached memory is one of the two low-power DDR generations that support that mode. Next, the master clock is moved onto the slow clock by clearing the source-select field in the current clock configuration. The sequencer then waits for the clock generator to report that the master clock is ready again. Last, it issues a keyed write that commands the shutdown.

Once that write has gone out, the sequencer stays in a terminal state until reset. A busy flag covers the whole run. Start pulses that arrive while the sequencer is busy, or after it has finished, have no effect.

Top module: `pwroff_sequencer`

## Requirements
- R1: While reset is held and in the cycle after it is released, all three write strobes and all three write-data buses are 0, and busy_o and done_o are 0.
- R2: A start pulse in the idle state with mem_type_i equal to 4 (LPDDR2) or 5 (LPDDR3) raises dram_wr_o for exactly one cycle, two cycles after the start edge. In that cycle dram_wdata_o carries the power-off word 0x00000003.
- R3: For any other mem_type_i code, no DRAM write is issued at all. The clock write then comes two cycles after the start edge.
- R4: The clock write comes in the cycle right after the DRAM write, or first if the DRAM step was skipped. clk_wr_o is high for one cycle, and clk_wdata_o equals clk_cfg_i with bits [1:0] (the source-select field) cleared.
- R5: mck_ready_i is ignored at the first clock edge after the clock write. From the next edge on, the first edge at which it is high is accepted. The shutdown write follows two cycles after that accepting edge. While ready stays low, no write is issued.
- R6: The shutdown write raises ctl_wr_o for one cycle with ctl_wdata_o = 0xA5000001 (key 0xA5 in bits 31:24, command bit 0 set).
- R7: At most one strobe is high in any cycle. Each data bus is 0 whenever its strobe is low.
- R8: busy_o is high from the cycle after the start edge until the shutdown write. It falls in the same cycle that ctl_wr_o rises, and done_o rises with it.
- R9: A start pulse while busy_o is high is ignored, including one that falls in the cycle in which ready is accepted. No step is repeated or restarted.
- R10: After the shutdown write, done_o stays high and busy_o stays low until reset. Start pulses then produce no writes.
- R11: The memory type is taken at the start edge. Changing mem_type_i later in the run does not change whether the DRAM step occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for the power-off run |
| mem_type_i | input | 3 | Attached memory type code (4 = LPDDR2, 5 = LPDDR3) |
| clk_cfg_i | input | 32 | Current master-clock configuration word |
| mck_ready_i | input | 1 | Master-clock-ready status |
| dram_wr_o | output | 1 | DRAM low-power register write strobe |
| dram_wdata_o | output | 32 | DRAM low-power register write data |
| clk_wr_o | output | 1 | Master-clock configuration write strobe |
| clk_wdata_o | output | 32 | Master-clock configuration write data |
| ctl_wr_o | output | 1 | Shutdown control register write strobe |
| ctl_wdata_o | output | 32 | Shutdown control register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Terminal state reached |

## Verification
Two events can meet in one cycle: a new start pulse, and the acceptance of the clock-ready flag that releases the final write. The bench provokes this by raising start_i together with mck_ready_i on the wait edge. It also pulses start_i just after the clock write. Both collisions are judged by requiring exactly one shutdown write at the computed cycle, with no repeated DRAM or clock write. The ready flag is also held high from before the run, so a stale flag that were wrongly accepted at the guard edge would show up as a shutdown write one cycle early.

// File: rtl/pwroff_pkg.sv
package pwroff_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAM,
    ST_CLK,
    ST_SETTLE,
    ST_WAIT,
    ST_CTL,
    ST_DONE
  } seq_state_t;

  function automatic logic state_is_busy(input seq_state_t s);
    return (s != ST_IDLE) && (s != ST_DONE);
  endfunction

endpackage

// File: rtl/pwroff_memclass.sv
module pwroff_memclass #(
  parameter int                    TYPE_W  = 3,
  parameter logic [TYPE_W-1:0]     CODE_A  = 3'd4,
  parameter logic [TYPE_W-1:0]     CODE_B  = 3'd5
) (
  input  logic [TYPE_W-1:0] type_i,
  output logic              is_lp_o
);

  localparam int NCODES = 2;
  logic [NCODES-1:0] hit;

  for (genvar g = 0; g < NCODES; g++) begin : g_cmp
    localparam logic [TYPE_W-1:0] CODE = (g == 0) ? CODE_A : CODE_B;
    assign hit[g] = (type_i == CODE);
  end

  assign is_lp_o = |hit;

endmodule

// File: rtl/pwroff_wrport.sv
module pwroff_wrport #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_o    <= 1'b0;
      wdata_o <= '0;
    end else begin
      wr_o    <= fire_i;
      wdata_o <= fire_i ? data_i : '0;
    end
  end

  // R7: data bus is quiet whenever the strobe is low
  p_quiet_data_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_o |-> (wdata_o == '0));

endmodule

// File: rtl/pwroff_fsm.sv
module pwroff_fsm
  import pwroff_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic is_lp_i,
  input  logic mck_ready_i,
  output logic fire_dram_o,
  output logic fire_clk_o,
  output logic fire_ctl_o,
  output logic busy_o,
  output logic done_o
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = is_lp_i ? ST_DRAM : ST_CLK;
      ST_DRAM:   state_d = ST_CLK;
      ST_CLK:    state_d = ST_SETTLE;
      ST_SETTLE: state_d = ST_WAIT;
      ST_WAIT:   if (mck_ready_i) state_d = ST_CTL;
      ST_CTL:    state_d = ST_DONE;
      ST_DONE:   state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign fire_dram_o = (state_q == ST_DRAM);
  assign fire_clk_o  = (state_q == ST_CLK);
  assign fire_ctl_o  = (state_q == ST_CTL);
  assign busy_o      = state_is_busy(state_q);
  assign done_o      = (state_q == ST_DONE);

  // R5: the edge right after the clock write never accepts ready
  p_settle_skips_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE) |=> (state_q == ST_WAIT));

  // R5: a high ready in the wait state releases the final step
  p_wait_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && mck_ready_i) |=> (state_q == ST_CTL));

  // R9: once started, the sequence never returns to idle before reset
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/pwroff_sequencer.sv
module pwroff_sequencer #(
  parameter int                    DW               = 32,
  parameter int                    MEM_TYPE_W       = 3,
  parameter logic [MEM_TYPE_W-1:0] MEM_LP2          = 3'd4,
  parameter logic [MEM_TYPE_W-1:0] MEM_LP3          = 3'd5,
  parameter int                    SRC_SEL_LSB      = 0,
  parameter int                    SRC_SEL_W        = 2,
  parameter logic [DW-1:0]         DRAM_PWROFF_WORD = 32'h0000_0003,
  parameter logic [7:0]            SHDN_KEY         = 8'hA5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [MEM_TYPE_W-1:0] mem_type_i,
  input  logic [DW-1:0]         clk_cfg_i,
  input  logic                  mck_ready_i,
  output logic                  dram_wr_o,
  output logic [DW-1:0]         dram_wdata_o,
  output logic                  clk_wr_o,
  output logic [DW-1:0]         clk_wdata_o,
  output logic                  ctl_wr_o,
  output logic [DW-1:0]         ctl_wdata_o,
  output logic                  busy_o,
  output logic                  done_o
);

  localparam logic [DW-1:0] SRC_SEL_MASK =
    ((DW'(1) << SRC_SEL_W) - DW'(1)) << SRC_SEL_LSB;
  localparam logic [DW-1:0] SHDN_WORD = {SHDN_KEY, {(DW-9){1'b0}}, 1'b1};

  logic is_lp;
  logic fire_dram, fire_clk, fire_ctl;

  pwroff_memclass #(
    .TYPE_W (MEM_TYPE_W),
    .CODE_A (MEM_LP2),
    .CODE_B (MEM_LP3)
  ) u_memclass (
    .type_i  (mem_type_i),
    .is_lp_o (is_lp)
  );

  pwroff_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .is_lp_i     (is_lp),
    .mck_ready_i (mck_ready_i),
    .fire_dram_o (fire_dram),
    .fire_clk_o  (fire_clk),
    .fire_ctl_o  (fire_ctl),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  pwroff_wrport #(.DW(DW)) u_dram_port (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire_dram),
    .data_i  (DRAM_PWROFF_WORD),
    .wr_o    (dram_wr_o),
    .wdata_o (dram_wdata_o)
  );

  pwroff_wrport #(.DW(DW)) u_clk_port (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire_clk),
    .data_i  (clk_cfg_i & ~SRC_SEL_MASK),
    .wr_o    (clk_wr_o),
    .wdata_o (clk_wdata_o)
  );

  pwroff_wrport #(.DW(DW)) u_ctl_port (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire_ctl),
    .data_i  (SHDN_WORD),
    .wr_o    (ctl_wr_o),
    .wdata_o (ctl_wdata_o)
  );

  // R7: strobes never overlap
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dram_wr_o, clk_wr_o, ctl_wr_o}));

  // R4: the clock switch directly follows the DRAM write
  p_dram_then_clk_r4: assert property (@(posedge clk) disable iff (rst)
    dram_wr_o |=> clk_wr_o);

  // R5: the shutdown write never follows the clock write at once
  p_no_early_ctl_r5: assert property (@(posedge clk) disable iff (rst)
    clk_wr_o |=> !ctl_wr_o);

  // R6: the shutdown write carries the key and the command bit
  p_keyed_ctl_r6: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_o |-> (ctl_wdata_o[DW-1 -: 8] == SHDN_KEY && ctl_wdata_o[0]));

  // R8: busy drops exactly as the shutdown write goes out
  p_busy_ends_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_o |-> (!busy_o && done_o));

  // R10: the terminal state holds until reset
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && !busy_o && !dram_wr_o && !clk_wr_o && !ctl_wr_o));

endmodule

// File: tb/pwroff_sequencer_test.sv
module pwroff_sequencer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  mem_type_i = 3'd0;
  logic [31:0] clk_cfg_i = 32'd0;
  logic        mck_ready_i = 1'b0;
  logic        dram_wr_o, clk_wr_o, ctl_wr_o, busy_o, done_o;
  logic [31:0] dram_wdata_o, clk_wdata_o, ctl_wdata_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwroff_sequencer uut (
    .clk(clk), .rst(rst), .start_i(start_i), .mem_type_i(mem_type_i),
    .clk_cfg_i(clk_cfg_i), .mck_ready_i(mck_ready_i),
    .dram_wr_o(dram_wr_o), .dram_wdata_o(dram_wdata_o),
    .clk_wr_o(clk_wr_o), .clk_wdata_o(clk_wdata_o),
    .ctl_wr_o(ctl_wr_o), .ctl_wdata_o(ctl_wdata_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic bit exp_is_lp(input logic [2:0] t);
    return (t == 3'd4) || (t == 3'd5);
  endfunction

  function automatic logic [31:0] exp_clk(input logic [31:0] cfg);
    return cfg & ~32'h3;
  endfunction

  localparam logic [31:0] EXP_DRAM = 32'h0000_0003;
  localparam logic [31:0] EXP_CTL  = 32'hA500_0001;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic check_quiet(input string req);
    check(req, "dram_wr", {31'd0, dram_wr_o}, 32'd0);
    check(req, "clk_wr",  {31'd0, clk_wr_o},  32'd0);
    check(req, "ctl_wr",  {31'd0, ctl_wr_o},  32'd0);
    check("R7", "dram data idle", dram_wdata_o, 32'd0);
    check("R7", "clk data idle",  clk_wdata_o,  32'd0);
    check("R7", "ctl data idle",  ctl_wdata_o,  32'd0);
  endtask

  task automatic run_seq(input logic [2:0] mtype, input logic [31:0] cfg,
                         input bit ready_pre, input int dly,
                         input bit poke, input bit flip_type);
    bit lp;
    lp = exp_is_lp(mtype);
    // reset and R1 checks
    @(negedge clk);
    rst = 1'b1; start_i = 1'b0; mck_ready_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_quiet("R1");
    check("R1", "busy in reset", {31'd0, busy_o}, 32'd0);
    check("R1", "done in reset", {31'd0, done_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1");
    check("R1", "busy after reset", {31'd0, busy_o}, 32'd0);
    // start pulse
    mem_type_i = mtype; clk_cfg_i = cfg; mck_ready_i = ready_pre;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (flip_type) mem_type_i = lp ? 3'd1 : 3'd4;   // R11 late change
    check("R8", "busy after start", {31'd0, busy_o}, 32'd1);
    check_quiet("R7");
    @(negedge clk);
    if (lp) begin
      check("R2", "dram strobe", {31'd0, dram_wr_o}, 32'd1);
      check("R2", "dram data", dram_wdata_o, EXP_DRAM);
      check("R11", "clk strobe not yet", {31'd0, clk_wr_o}, 32'd0);
      @(negedge clk);
      check("R2", "dram one cycle", {31'd0, dram_wr_o}, 32'd0);
    end else begin
      check("R3", "dram skipped", {31'd0, dram_wr_o}, 32'd0);
    end
    check("R4", "clk strobe", {31'd0, clk_wr_o}, 32'd1);
    check("R4", "clk data", clk_wdata_o, exp_clk(cfg));
    check("R7", "ctl during clk", {31'd0, ctl_wr_o}, 32'd0);
    if (poke) start_i = 1'b1;                        // R9 start while busy
    @(negedge clk);
    start_i = 1'b0;
    check_quiet("R5");
    check("R8", "busy in settle", {31'd0, busy_o}, 32'd1);
    mck_ready_i = (dly == 0);
    if (dly == 0 && poke) start_i = 1'b1;            // R9 same-cycle collision
    for (int i = 1; i <= dly; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      check_quiet("R5");
      check("R8", "busy while waiting", {31'd0, busy_o}, 32'd1);
      if (i == dly) begin
        mck_ready_i = 1'b1;
        if (poke) start_i = 1'b1;
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    check_quiet("R5");
    check("R8", "busy before shutdown", {31'd0, busy_o}, 32'd1);
    @(negedge clk);
    check("R6", "ctl strobe", {31'd0, ctl_wr_o}, 32'd1);
    check("R6", "ctl data", ctl_wdata_o, EXP_CTL);
    check("R9", "no dram repeat", {31'd0, dram_wr_o}, 32'd0);
    check("R9", "no clk repeat", {31'd0, clk_wr_o}, 32'd0);
    check("R8", "busy falls", {31'd0, busy_o}, 32'd0);
    check("R8", "done rises", {31'd0, done_o}, 32'd1);
    // terminal: starts ignored
    for (int j = 0; j < 4; j++) begin
      start_i = (j % 2 == 0);
      mck_ready_i = $urandom_range(0, 1);
      mem_type_i = 3'd4;
      @(negedge clk);
      check_quiet("R10");
      check("R10", "done held", {31'd0, done_o}, 32'd1);
      check("R10", "busy low", {31'd0, busy_o}, 32'd0);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd90517));
    // directed corners
    run_seq(3'd4, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 1'b0);  // R2 LPDDR2
    run_seq(3'd5, 32'h0000_0003, 1'b1, 3, 1'b1, 1'b0);  // R2 LPDDR3, stale ready
    run_seq(3'd0, 32'h1234_5677, 1'b1, 0, 1'b1, 1'b0);  // R3, R9 collision
    run_seq(3'd7, 32'hA5A5_5A5A, 1'b0, 5, 1'b0, 1'b1);  // R3, R11
    run_seq(3'd4, 32'h0000_0001, 1'b1, 2, 1'b0, 1'b1);  // R11 lp then flipped
    // constrained random
    for (int k = 0; k < 40; k++) begin
      run_seq(3'($urandom_range(0, 7)), $urandom(), 1'($urandom_range(0, 1)),
              $urandom_range(0, 6), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)));
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule